// File: doc/BRIEF.md
# Per-CPU Doorbell Unit

This block gives each of up to four processors a 32-bit doorbell cause register and a 32-bit doorbell enable (mask) register. Any bus master rings doorbells by writing one trigger word. The word holds a target-processor bitmap in bits starting at bit 8 and a doorbell number in bits [4:0]. The doorbell bit is then set in the cause register of every processor named in the bitmap. A separate inbound port carries message-signalled writes in the same word format, so an endpoint's message write rings a doorbell through the same decoding as a software trigger.

Doorbells 0..7 form the inter-processor group and doorbells 16..31 form the message group. Each group drives its own summary line per processor. A summary line is the OR of the pending, enabled bits in its group, further gated by a per-processor group enable. The per-CPU registers are reached through the bus with a processor-id input: the register decoded is the one belonging to the processor named on `bus_cpu`. The block has no state machine; all behaviour is register updates on the clock edge.

Top module: `db_unit`

## Requirements
- R1: A bus write of word W to offset 0x04 sets cause bit W[4:0] of every processor c whose bit W[8+c] is 1, and changes no other cause bit.
- R2: Bits W[7:5] of a trigger word and bitmap bits for processors at or above NCPU have no effect.
- R3: A pulse on `msi_wr` with `msi_data` acts as a trigger write of that word; it can coincide with a bus trigger, and both take effect.
- R4: A bus write of D to offset 0x08 replaces the selected processor's cause with cause AND D: bits written 0 clear, bits written 1 keep their value.
- R5: When a trigger sets a bit in the same cycle that a cause write clears it, the bit ends up set.
- R6: Offset 0x0C is the selected processor's doorbell enable register, written whole; reads of 0x08 and 0x0C return the selected processor's cause and enable, and other offsets read 0.
- R7: `ipi_irq[c]` is 1 exactly when the inter-processor group of processor c is enabled and some bit in [7:0] is both pending and enabled.
- R8: `msg_irq[c]` is 1 exactly when the message group of processor c is enabled and some bit in [31:16] is both pending and enabled.
- R9: Writing 0 to offset 0x4C enables the selected processor's inter-processor group, writing 1 enables its message group; writing 0 or 1 to offset 0x48 disables the same group; other data values at these offsets have no effect.
- R10: After reset all cause and enable registers are 0, both groups of every processor are disabled, and all summary lines are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_cpu | input | CPUW | Processor whose per-CPU registers are addressed |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`/`bus_cpu`, combinational |
| msi_wr | input | 1 | Inbound message write strobe |
| msi_data | input | 32 | Inbound message word, trigger format |
| ipi_irq | output | NCPU | Inter-processor summary per processor |
| msg_irq | output | NCPU | Message summary per processor |

## Verification
The trigger decoder is swept over every doorbell number and every processor bitmap, then read back from each processor; this separates a wrong bit index from a wrong target selection. The same sweep repeats with junk in bits [7:5] and in bitmap bits above the implemented count, which exposes decoders that use too wide a field. Summary lines are tried with pending bits inside and outside each group, under all enable and group-gate combinations, so that a swapped group range or a missing gate shows up. A simultaneous clear and message write tells a set-wins merge apart from a clear-wins merge.

// File: rtl/db_pkg.sv
package db_pkg;
    localparam int DBW   = 32;
    localparam int ADDRW = 8;
    localparam logic [ADDRW-1:0] OFS_TRIG   = 8'h04;
    localparam logic [ADDRW-1:0] OFS_CAUSE  = 8'h08;
    localparam logic [ADDRW-1:0] OFS_ENA    = 8'h0C;
    localparam logic [ADDRW-1:0] OFS_GRP_OFF = 8'h48;
    localparam logic [ADDRW-1:0] OFS_GRP_ON  = 8'h4C;
    localparam int IPI_LO = 0;
    localparam int IPI_HI = 7;
    localparam int MSG_LO = 16;
    localparam int MSG_HI = 31;
    localparam int MAP_LSB = 8;
    localparam int NUMW = 5;
endpackage

// File: rtl/db_trig_decode.sv
module db_trig_decode
    import db_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                      vld,
    input  logic [DBW-1:0]            word,
    output logic [NCPU-1:0][DBW-1:0]  set_vec
);
    logic [DBW-1:0] onehot;

    always_comb begin
        onehot = '0;
        onehot[word[NUMW-1:0]] = 1'b1;
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        assign set_vec[c] = (vld && word[MAP_LSB+c]) ? onehot : '0;
    end
endmodule

// File: rtl/db_cpu_bank.sv
module db_cpu_bank
    import db_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDRW-1:0]     addr,
    input  logic [DBW-1:0]       wdata,
    input  logic [DBW-1:0]       set_vec,
    output logic [DBW-1:0]       cause,
    output logic [DBW-1:0]       ena,
    output logic                 ipi_irq,
    output logic                 msg_irq
);
    logic ipi_grp_q, msg_grp_q;
    logic wr_me;
    logic [DBW-1:0] cause_kept;

    assign wr_me = wr && sel;

    always_comb begin
        cause_kept = cause;
        if (wr_me && addr == OFS_CAUSE)
            cause_kept = cause & wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause     <= '0;
            ena       <= '0;
            ipi_grp_q <= 1'b0;
            msg_grp_q <= 1'b0;
        end else begin
            cause <= cause_kept | set_vec;
            if (wr_me && addr == OFS_ENA)
                ena <= wdata;
            if (wr_me && (addr == OFS_GRP_ON || addr == OFS_GRP_OFF)) begin
                if (wdata == 32'd0)
                    ipi_grp_q <= (addr == OFS_GRP_ON);
                else if (wdata == 32'd1)
                    msg_grp_q <= (addr == OFS_GRP_ON);
            end
        end
    end

    always_comb begin
        ipi_irq = ipi_grp_q && |(cause[IPI_HI:IPI_LO] & ena[IPI_HI:IPI_LO]);
        msg_irq = msg_grp_q && |(cause[MSG_HI:MSG_LO] & ena[MSG_HI:MSG_LO]);
    end
endmodule

// File: rtl/db_unit.sv
module db_unit
    import db_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [CPUW-1:0]  bus_cpu,
    input  logic [ADDRW-1:0] bus_addr,
    input  logic [DBW-1:0]   bus_wdata,
    output logic [DBW-1:0]   bus_rdata,
    input  logic             msi_wr,
    input  logic [DBW-1:0]   msi_data,
    output logic [NCPU-1:0]  ipi_irq,
    output logic [NCPU-1:0]  msg_irq
);
    logic [NCPU-1:0][DBW-1:0] set_bus, set_msi;
    logic [NCPU-1:0][DBW-1:0] cause_q, mask_q;
    logic bus_trig;

    assign bus_trig = bus_wr && bus_addr == OFS_TRIG;

    db_trig_decode #(.NCPU(NCPU)) u_dec_bus (
        .vld(bus_trig), .word(bus_wdata), .set_vec(set_bus));

    db_trig_decode #(.NCPU(NCPU)) u_dec_msi (
        .vld(msi_wr), .word(msi_data), .set_vec(set_msi));

    for (genvar c = 0; c < NCPU; c++) begin : g_bank
        db_cpu_bank u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (bus_cpu == CPUW'(c)),
            .wr      (bus_wr),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .set_vec (set_bus[c] | set_msi[c]),
            .cause   (cause_q[c]),
            .ena     (mask_q[c]),
            .ipi_irq (ipi_irq[c]),
            .msg_irq (msg_irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_cpu) < NCPU) begin
            if (bus_addr == OFS_CAUSE)
                bus_rdata = cause_q[bus_cpu];
            else if (bus_addr == OFS_ENA)
                bus_rdata = mask_q[bus_cpu];
        end
    end
endmodule

// File: rtl/db_unit_chk.sv
module db_unit_chk
    import db_pkg::*;
#(
    parameter int NCPU = 4,
    localparam int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic [CPUW-1:0]           bus_cpu,
    input logic [ADDRW-1:0]          bus_addr,
    input logic [DBW-1:0]            bus_wdata,
    input logic                      msi_wr,
    input logic [DBW-1:0]            msi_data,
    input logic [NCPU-1:0]           ipi_irq,
    input logic [NCPU-1:0]           msg_irq,
    input logic [NCPU-1:0][DBW-1:0]  cause,
    input logic [NCPU-1:0][DBW-1:0]  mask
);
    for (genvar c = 0; c < NCPU; c++) begin : g_c
        // R3
        msi_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (msi_wr && msi_data[MAP_LSB+c]) |=> cause[c][$past(msi_data[NUMW-1:0])]);

        // R4
        clear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!msi_wr && bus_wr && bus_addr == OFS_CAUSE && bus_cpu == CPUW'(c))
            |=> cause[c] == ($past(cause[c]) & $past(bus_wdata)));

        // R7
        ipi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ipi_irq[c] |-> |(cause[c][IPI_HI:IPI_LO] & mask[c][IPI_HI:IPI_LO]));

        // R8
        msg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            msg_irq[c] |-> |(cause[c][MSG_HI:MSG_LO] & mask[c][MSG_HI:MSG_LO]));
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !msi_wr) |=> $stable(cause));
endmodule

bind db_unit db_unit_chk #(.NCPU(NCPU)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .msi_wr(msi_wr),
    .msi_data(msi_data), .ipi_irq(ipi_irq), .msg_irq(msg_irq),
    .cause(cause_q), .mask(mask_q));

// File: tb/db_unit_test.sv
module db_unit_test;
    localparam int NCPU = 4;
    localparam int CPUW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [CPUW-1:0] bus_cpu = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msi_wr = 1'b0;
    logic [31:0] msi_data = '0;
    logic [NCPU-1:0] ipi_irq, msg_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    db_unit #(.NCPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msi_wr(msi_wr), .msi_data(msi_data), .ipi_irq(ipi_irq), .msg_irq(msg_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = CPUW'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = CPUW'(cpu); bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clear_all();
        for (int c = 0; c < NCPU; c++) wr(c, 8'h08, 32'h0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        for (int c = 0; c < NCPU; c++) begin
            rd(c, 8'h08, r); chk("R10 cause", r, 0);
            rd(c, 8'h0C, r); chk("R10 mask", r, 0);
        end
        chk("R10 irq", {ipi_irq, msg_irq}, 0);

        // R1 sweep every doorbell number and every bitmap
        for (int n = 0; n < 32; n++) begin
            for (int m = 0; m < 16; m++) begin
                clear_all();
                wr(0, 8'h04, (32'(m) << 8) | 32'(n));
                for (int c = 0; c < NCPU; c++) begin
                    rd(c, 8'h08, r);
                    chk("R1 trigger", r, m[c] ? (32'h1 << n) : 32'h0);
                end
            end
        end

        // R2 junk in bits 7:5 and bitmap bits above NCPU
        for (int n = 0; n < 32; n += 3) begin
            clear_all();
            wr(2, 8'h04, 32'hFFFF_F0E0 | (32'h5 << 8) | 32'(n));
            for (int c = 0; c < NCPU; c++) begin
                rd(c, 8'h08, r);
                chk("R2 ignored bits", r, (c == 0 || c == 2) ? (32'h1 << n) : 32'h0);
            end
        end

        // R3 message port together with bus trigger
        clear_all();
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = (32'h2 << 8) | 32'd3;
        msi_wr = 1'b1; msi_data = (32'h2 << 8) | 32'd21;
        @(negedge clk);
        bus_wr = 1'b0; msi_wr = 1'b0;
        rd(1, 8'h08, r); chk("R3 both", r, (32'h1 << 3) | (32'h1 << 21));
        rd(0, 8'h08, r); chk("R3 others", r, 0);

        // R4 write-zero-to-clear
        wr(1, 8'h08, ~(32'h1 << 21));
        rd(1, 8'h08, r); chk("R4 clear", r, 32'h8);
        wr(1, 8'h08, 32'hFFFF_FFFF);
        rd(1, 8'h08, r); chk("R4 keep", r, 32'h8);

        // R5 set wins over clear in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = 1; bus_addr = 8'h08; bus_wdata = 32'h0;
        msi_wr = 1'b1; msi_data = (32'h2 << 8) | 32'd3;
        @(negedge clk);
        bus_wr = 1'b0; msi_wr = 1'b0;
        rd(1, 8'h08, r); chk("R5 set wins", r, 32'h8);

        // R6 mask register and reads
        wr(3, 8'h0C, 32'hA5A5_0F0F);
        rd(3, 8'h0C, r); chk("R6 mask rd", r, 32'hA5A5_0F0F);
        rd(2, 8'h0C, r); chk("R6 other cpu", r, 0);
        rd(3, 8'h10, r); chk("R6 other ofs", r, 0);

        // R7/R8/R9 summaries on cpu 1: pending bits 3 and 20
        clear_all();
        wr(0, 8'h04, (32'h2 << 8) | 32'd3);
        wr(0, 8'h04, (32'h2 << 8) | 32'd20);
        wr(0, 8'h04, (32'h2 << 8) | 32'd10);
        for (int g = 0; g < 4; g++) begin
            wr(1, g[0] ? 8'h4C : 8'h48, 32'd0);
            wr(1, g[1] ? 8'h4C : 8'h48, 32'd1);
            for (int mk = 0; mk < 4; mk++) begin
                logic [31:0] mv;
                mv = (mk[0] ? 32'h8 : 32'h0) | (mk[1] ? 32'h0010_0000 : 32'h0) | 32'h400;
                wr(1, 8'h0C, mv);
                @(negedge clk);
                chk("R7 ipi", 32'(ipi_irq), (g[0] && mk[0]) ? 32'h2 : 32'h0);
                chk("R8 msg", 32'(msg_irq), (g[1] && mk[1]) ? 32'h2 : 32'h0);
            end
        end
        // R9 other values ignored: groups now both on, mask both
        wr(1, 8'h48, 32'd5);
        wr(1, 8'h48, 32'h100);
        @(negedge clk);
        chk("R9 ignored", {28'h0, ipi_irq[1], msg_irq[1], 2'b00}, 32'hC);
        wr(1, 8'h48, 32'd1);
        @(negedge clk);
        chk("R9 msg off", {30'h0, ipi_irq[1], msg_irq[1]}, 32'h2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule